// File: doc/BRIEF.md
# VGA Read Latch and Color Compare

This block sits on the read side of a planar VGA frame buffer. Each frame-buffer read returns one 32-bit word that holds four 8-bit planes, with plane p in bits 8p+7 to 8p. On the read-data valid strobe the whole word is captured into a display latch. In the same cycle one byte is formed for the host and registered.

Two read modes are supported. In mode 0 the host byte is one plane byte. The plane index comes from the 2-bit map select, unless a chained addressing mode is active; in that case the plane index supplied by the address mapper is used instead. In mode 1 the host byte is a color compare result: every bit position reports whether all planes enabled by the compare mask match their compare color bit.

Software can write the latch directly, and later frame-buffer writes may use the latch contents as a data source.

Top module: `vga_read_path`

## Requirements
- R1: While rst_n is low, and on the first clock edge after it, latch_q and host_byte are 0.
- R2: When rd_valid is high at a clock edge and latch_wr_en is low, latch_q equals rd_data from that edge onward. It is visible one cycle after the strobe.
- R3: When latch_wr_en is high at a clock edge, latch_q takes latch_wr_data. This write wins over a read strobe in the same cycle.
- R4: With neither rd_valid nor latch_wr_en high, latch_q holds its value.
- R5: In read mode 0 (rd_mode=0) with chain_active=0, host_byte becomes the byte of plane map_sel, which is bits 8*map_sel+7 to 8*map_sel of rd_data. It updates on the edge where rd_valid is high.
- R6: In read mode 0 with chain_active=1, chain_plane selects the plane byte and map_sel has no effect.
- R7: In read mode 1 (rd_mode=1), host_byte bit i is 1 exactly when every plane p with cmp_mask[p]=1 has bit i equal to cmp_color[p]. map_sel, chain_active and chain_plane have no effect.
- R8: In read mode 1 with cmp_mask=0, host_byte becomes 8'hFF.
- R9: host_byte changes only on an edge with rd_valid high. Software latch writes and control changes without a strobe leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_data | input | 32 | Four-plane frame-buffer read data |
| rd_valid | input | 1 | Read data valid strobe |
| map_sel | input | 2 | Plane select for read mode 0 |
| rd_mode | input | 1 | 0: plane byte, 1: color compare |
| cmp_mask | input | 4 | Planes included in color compare |
| cmp_color | input | 4 | Per-plane compare color bit |
| chain_active | input | 1 | Chained addressing active; plane override in use |
| chain_plane | input | 2 | Plane chosen by the address mapper |
| latch_wr_en | input | 1 | Software write to the display latch |
| latch_wr_data | input | 32 | Software latch write value |
| host_byte | output | 8 | Byte returned to the host |
| latch_q | output | 32 | Display latch contents |

## Verification
The hardest case is a cycle in which a read strobe and a software latch write arrive together. The two outputs must then part ways: the latch takes the software word, while the host byte is still formed from the read data. The bench drives both in one cycle, using distinct words, so that the two results can be told apart. It also issues software writes and control changes with no strobe, to show that the host byte stays put. In the compare-mode vectors, the map select and the chain override are set to misleading values, so that any leak from them into the result shows up.

// File: rtl/vga_rd_pkg.sv
package vga_rd_pkg;
  localparam int PLANES  = 4;
  localparam int PLANE_W = 8;
  localparam int WORD_W  = PLANES * PLANE_W;
  localparam int SEL_W   = $clog2(PLANES);

  function automatic logic [PLANE_W-1:0] pick_byte(input logic [WORD_W-1:0] d,
                                                   input logic [SEL_W-1:0] sel);
    return d[PLANE_W*sel +: PLANE_W];
  endfunction

  function automatic logic [PLANE_W-1:0] color_match(input logic [WORD_W-1:0] d,
                                                     input logic [PLANES-1:0] mask,
                                                     input logic [PLANES-1:0] color);
    logic [PLANE_W-1:0] r;
    r = '1;
    for (int p = 0; p < PLANES; p++) begin
      if (mask[p]) r &= ~(d[PLANE_W*p +: PLANE_W] ^ {PLANE_W{color[p]}});
    end
    return r;
  endfunction
endpackage

// File: rtl/vga_plane_sel.sv
module vga_plane_sel
  import vga_rd_pkg::*;
(
  input  logic [SEL_W-1:0] map_sel,
  input  logic             chain_active,
  input  logic [SEL_W-1:0] chain_plane,
  output logic [SEL_W-1:0] plane
);
  always_comb begin
    plane = chain_active ? chain_plane : map_sel;
  end
endmodule

// File: rtl/vga_color_cmp.sv
module vga_color_cmp
  import vga_rd_pkg::*;
(
  input  logic [WORD_W-1:0]  data,
  input  logic [PLANES-1:0]  mask,
  input  logic [PLANES-1:0]  color,
  output logic [PLANE_W-1:0] match
);
  always_comb begin
    match = color_match(data, mask, color);
  end
endmodule

// File: rtl/vga_disp_latch.sv
module vga_disp_latch
  import vga_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_rd,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              load_sw,
  input  logic [WORD_W-1:0] sw_word,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       q <= '0;
    else if (load_sw) q <= sw_word;
    else if (load_rd) q <= rd_word;
  end

  a_r2_read_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (load_rd && !load_sw) |=> (q == $past(rd_word)));
  a_r3_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_sw |=> (q == $past(sw_word)));
  a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_rd && !load_sw) |=> $stable(q));
endmodule

// File: rtl/vga_read_path.sv
module vga_read_path
  import vga_rd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] rd_data,
  input  logic        rd_valid,
  input  logic [1:0]  map_sel,
  input  logic        rd_mode,
  input  logic [3:0]  cmp_mask,
  input  logic [3:0]  cmp_color,
  input  logic        chain_active,
  input  logic [1:0]  chain_plane,
  input  logic        latch_wr_en,
  input  logic [31:0] latch_wr_data,
  output logic [7:0]  host_byte,
  output logic [31:0] latch_q
);
  logic [SEL_W-1:0]   eff_plane;
  logic [PLANE_W-1:0] cmp_byte;
  logic [PLANE_W-1:0] plane_byte;
  logic [PLANE_W-1:0] next_host;

  vga_plane_sel u_sel (
    .map_sel      (map_sel),
    .chain_active (chain_active),
    .chain_plane  (chain_plane),
    .plane        (eff_plane)
  );

  vga_color_cmp u_cmp (
    .data  (rd_data),
    .mask  (cmp_mask),
    .color (cmp_color),
    .match (cmp_byte)
  );

  vga_disp_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_rd (rd_valid),
    .rd_word (rd_data),
    .load_sw (latch_wr_en),
    .sw_word (latch_wr_data),
    .q       (latch_q)
  );

  always_comb begin
    plane_byte = pick_byte(rd_data, eff_plane);
    next_host  = rd_mode ? cmp_byte : plane_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        host_byte <= '0;
    else if (rd_valid) host_byte <= next_host;
  end

  // R5/R6: the returned byte matches the latched word at the chosen plane
  a_r5_plane_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_mode && !latch_wr_en) |=>
      (host_byte == pick_byte(latch_q, $past(eff_plane))));
  a_r6_chain_override: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_mode && chain_active) |=>
      (host_byte == pick_byte($past(rd_data), $past(chain_plane))));
  a_r8_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_mode && cmp_mask == '0) |=> (host_byte == 8'hFF));
  a_r9_host_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> $stable(host_byte));
endmodule

// File: tb/vga_read_path_test.sv
module vga_read_path_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] rd_data = 0;
  logic        rd_valid = 0;
  logic [1:0]  map_sel = 0;
  logic        rd_mode = 0;
  logic [3:0]  cmp_mask = 0;
  logic [3:0]  cmp_color = 0;
  logic        chain_active = 0;
  logic [1:0]  chain_plane = 0;
  logic        latch_wr_en = 0;
  logic [31:0] latch_wr_data = 0;
  logic [7:0]  host_byte;
  logic [31:0] latch_q;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vga_read_path uut (.*);

  localparam int NV = 9;
  localparam logic [31:0] V_DATA  [NV] = '{32'h44332211, 32'h44332211, 32'h44332211,
    32'h44332211, 32'hFF00F00F, 32'hFF00F00F, 32'hFF00F00F, 32'h12345678, 32'hA5A5A5A5};
  localparam logic        V_MODE  [NV] = '{0, 0, 0, 0, 1, 1, 1, 1, 1};
  localparam logic [1:0]  V_MAP   [NV] = '{0, 2, 3, 3, 2, 0, 1, 3, 2};
  localparam logic        V_CHAIN [NV] = '{0, 0, 0, 1, 1, 0, 0, 1, 1};
  localparam logic [1:0]  V_CPL   [NV] = '{3, 1, 0, 1, 0, 3, 2, 1, 3};
  localparam logic [3:0]  V_MASK  [NV] = '{0, 0, 0, 0, 4'hF, 4'h2, 4'h0, 4'h1, 4'h5};
  localparam logic [3:0]  V_COLOR [NV] = '{0, 0, 0, 0, 4'h9, 4'h2, 4'h6, 4'h0, 4'h5};
  localparam logic [7:0]  V_EXP   [NV] = '{8'h11, 8'h33, 8'h44, 8'h22,
    8'h0F, 8'hF0, 8'hFF, 8'h87, 8'hA5};
  localparam string       V_REQ   [NV] = '{"R5", "R5", "R5", "R6", "R7", "R7", "R8", "R7", "R7"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [31:0] d, input logic m, input logic [1:0] ms,
                         input logic ch, input logic [1:0] cp,
                         input logic [3:0] mk, input logic [3:0] co);
    @(negedge clk);
    rd_data = d; rd_mode = m; map_sel = ms; chain_active = ch; chain_plane = cp;
    cmp_mask = mk; cmp_color = co; rd_valid = 1;
    @(negedge clk);
    rd_valid = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", latch_q, 0);
    check("R1", host_byte, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", {24'h0, host_byte}, 0);

    for (int i = 0; i < NV; i++) begin
      do_read(V_DATA[i], V_MODE[i], V_MAP[i], V_CHAIN[i], V_CPL[i], V_MASK[i], V_COLOR[i]);
      check(V_REQ[i], {24'h0, host_byte}, {24'h0, V_EXP[i]});
      check("R2", latch_q, V_DATA[i]);
    end

    // R4/R9: idle cycles and control changes without a strobe
    @(negedge clk);
    rd_mode = 0; map_sel = 0; chain_active = 0; rd_data = 32'hDEADBEEF;
    repeat (3) @(negedge clk);
    check("R4", latch_q, 32'hA5A5A5A5);
    check("R9", {24'h0, host_byte}, 32'hA5);

    // R3/R9: software write alone
    latch_wr_en = 1; latch_wr_data = 32'hCAFE0123;
    @(negedge clk);
    latch_wr_en = 0;
    check("R3", latch_q, 32'hCAFE0123);
    check("R9", {24'h0, host_byte}, 32'hA5);

    // R3: simultaneous read and software write
    rd_data = 32'h55667788; rd_mode = 0; map_sel = 1; rd_valid = 1;
    latch_wr_en = 1; latch_wr_data = 32'h0BADF00D;
    @(negedge clk);
    rd_valid = 0; latch_wr_en = 0;
    check("R3", latch_q, 32'h0BADF00D);
    check("R3", {24'h0, host_byte}, 32'h77);

    // R6: chain override ignores map select
    do_read(32'h01020304, 0, 2'd0, 1, 2'd2, 4'h0, 4'h0);
    check("R6", {24'h0, host_byte}, 32'h02);

    // R1: reset clears again mid-run
    rst_n = 0;
    @(negedge clk);
    check("R1", latch_q, 0);
    check("R1", {24'h0, host_byte}, 0);
    rst_n = 1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule